// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multi-cycle processor, built around a microcode store. A register holds the microaddress of the current microinstruction. Each stored word has two parts: a 16-bit set of datapath control bits, which goes straight to the outputs, and a 2-bit sequencing code. The sequencing code tells the address-select logic how to form the next microaddress. It can take the current address plus one from an incrementer, look the instruction opcode up in one of two dispatch tables, or jump back to the fetch word at address 0.

The microprogram is a constant inside the block and covers five instruction classes: register-register ALU, load, store, branch-on-equal and jump. Every instruction runs a fetch word and then a decode word. The first dispatch table sends each class to its own execution sequence. Load and store share an address-compute word, and the second dispatch table separates them after it. The surrounding datapath holds the opcode from its instruction register and keeps it stable while an instruction runs. It uses the control bits in the cycle they are presented.

Top module: `mseq_ctrl`

## Requirements
- R1: While `rst_n` is low, and for the first two rising clock edges after it goes high, `ctl` holds the fetch word 0x0429.
- R2: Every instruction starts with the fetch word 0x0429, followed one cycle later by the decode word 0x0C00.
- R3: A word whose sequencing code is 0 (increment) is followed by the word at the next microaddress. This covers fetch to decode, load read to load write-back, and ALU execute to ALU write-back.
- R4: After decode, the first dispatch table picks the next word from `opcode`. Opcode 0x00 gives ALU execute 0x2200, 0x23 and 0x2B give address compute 0x0A00, 0x04 gives branch 0x5202, and 0x02 gives jump 0x8001.
- R5: After address compute, the second dispatch table picks the next word from the opcode present in that cycle. Opcode 0x23 gives load read 0x000C, which is then followed by load write-back 0x0140. Opcode 0x2B gives store write 0x0014.
- R6: The last word of each instruction carries sequencing code 3 and is followed by the fetch word. The last words are load write-back, store write, ALU write-back 0x0180, branch and jump.
- R7: An opcode with no entry in the first dispatch table sends decode straight back to fetch.
- R8: An opcode with no entry in the second dispatch table sends address compute back to fetch.
- R9: `ctl` bit layout: [0] PC write, [1] PC write if equal, [2] address from ALU-out, [3] memory read, [4] memory write, [5] instruction-register write, [6] write-back from memory, [7] destination from rd field, [8] register write, [9] ALU A from register, [11:10] ALU B select, [13:12] ALU operation, [15:14] PC source.
- R10: Pulling `rst_n` low in the middle of an instruction forces the fetch word at once. After release, the sequence starts again from fetch.
- R11: Memory read (bit 3) and memory write (bit 4) are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` inside the block |
| opcode | input | OPC_W (6) | Opcode field held by the instruction register |
| ctl | output | 16 | Datapath control bits of the current microinstruction |

## Verification
The bench uses the default parameters. The opcode is 6 bits wide, and the five mapped codes leave many unmapped values free, so the bench can send decode back to fetch with an arbitrary code. The bench also switches the opcode between decode and address compute. This drives the second table with a branch code, which has no entry there, and with a store code after a load decode, which shows that the second table reads the opcode live. With the fixed 4-bit microaddress, every one of the ten microprogram words is reached and compared against the bit layout given in R9.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int CTL_W   = 16;
  localparam int SEQ_W   = 2;
  localparam int UA_W    = 4;
  localparam int UA_USED = 10;

  typedef logic [UA_W-1:0] uaddr_t;

  typedef enum logic [SEQ_W-1:0] {
    SQ_INC   = 2'd0,
    SQ_DSP1  = 2'd1,
    SQ_DSP2  = 2'd2,
    SQ_FETCH = 2'd3
  } seq_e;

  localparam uaddr_t UA_FETCH  = 4'd0;
  localparam uaddr_t UA_DECODE = 4'd1;
  localparam uaddr_t UA_MADDR  = 4'd2;
  localparam uaddr_t UA_LDRD   = 4'd3;
  localparam uaddr_t UA_LDWB   = 4'd4;
  localparam uaddr_t UA_STWR   = 4'd5;
  localparam uaddr_t UA_REXE   = 4'd6;
  localparam uaddr_t UA_RWB    = 4'd7;
  localparam uaddr_t UA_BR     = 4'd8;
  localparam uaddr_t UA_JMP    = 4'd9;

  localparam int B_MEMRD = 3;
  localparam int B_MEMWR = 4;
endpackage

// File: rtl/mseq_rst_sync.sv
module mseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
(
  input  uaddr_t           addr,
  output logic [CTL_W-1:0] ctl,
  output seq_e             seq
);
  // word = {sequencing code, control bits}
  always_comb begin
    case (addr)
      UA_FETCH:  begin ctl = 16'h0429; seq = SQ_INC;   end // read mem, load IR, PC+4
      UA_DECODE: begin ctl = 16'h0C00; seq = SQ_DSP1;  end // branch target precompute
      UA_MADDR:  begin ctl = 16'h0A00; seq = SQ_DSP2;  end // base + offset
      UA_LDRD:   begin ctl = 16'h000C; seq = SQ_INC;   end
      UA_LDWB:   begin ctl = 16'h0140; seq = SQ_FETCH; end
      UA_STWR:   begin ctl = 16'h0014; seq = SQ_FETCH; end
      UA_REXE:   begin ctl = 16'h2200; seq = SQ_INC;   end
      UA_RWB:    begin ctl = 16'h0180; seq = SQ_FETCH; end
      UA_BR:     begin ctl = 16'h5202; seq = SQ_FETCH; end
      UA_JMP:    begin ctl = 16'h8001; seq = SQ_FETCH; end
      default:   begin ctl = '0;       seq = SQ_FETCH; end
    endcase
  end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
#(
  parameter int                OPC_W     = 6,
  parameter logic [OPC_W-1:0] OP_RTYPE  = 'h00,
  parameter logic [OPC_W-1:0] OP_LOAD   = 'h23,
  parameter logic [OPC_W-1:0] OP_STORE  = 'h2B,
  parameter logic [OPC_W-1:0] OP_BRANCH = 'h04,
  parameter logic [OPC_W-1:0] OP_JUMP   = 'h02
) (
  input  uaddr_t           upc,
  input  seq_e             seq,
  input  logic [OPC_W-1:0] opcode,
  output uaddr_t           upc_nxt
);
  uaddr_t inc_a, dsp1_a, dsp2_a;

  always_comb inc_a = upc + uaddr_t'(1);

  always_comb begin
    if      (opcode == OP_RTYPE)  dsp1_a = UA_REXE;
    else if (opcode == OP_LOAD)   dsp1_a = UA_MADDR;
    else if (opcode == OP_STORE)  dsp1_a = UA_MADDR;
    else if (opcode == OP_BRANCH) dsp1_a = UA_BR;
    else if (opcode == OP_JUMP)   dsp1_a = UA_JMP;
    else                          dsp1_a = UA_FETCH;
  end

  always_comb begin
    if      (opcode == OP_LOAD)  dsp2_a = UA_LDRD;
    else if (opcode == OP_STORE) dsp2_a = UA_STWR;
    else                         dsp2_a = UA_FETCH;
  end

  always_comb begin
    case (seq)
      SQ_INC:  upc_nxt = inc_a;
      SQ_DSP1: upc_nxt = dsp1_a;
      SQ_DSP2: upc_nxt = dsp2_a;
      default: upc_nxt = UA_FETCH;
    endcase
  end
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int                OPC_W     = 6,
  parameter logic [OPC_W-1:0] OP_RTYPE  = 'h00,
  parameter logic [OPC_W-1:0] OP_LOAD   = 'h23,
  parameter logic [OPC_W-1:0] OP_STORE  = 'h2B,
  parameter logic [OPC_W-1:0] OP_BRANCH = 'h04,
  parameter logic [OPC_W-1:0] OP_JUMP   = 'h02
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OPC_W-1:0]          opcode,
  output logic [mseq_pkg::CTL_W-1:0] ctl
);
  logic   rst_q;
  uaddr_t upc, upc_nxt;
  seq_e   seq;

  mseq_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  mseq_rom u_rom (
    .addr (upc),
    .ctl  (ctl),
    .seq  (seq)
  );

  mseq_next #(
    .OPC_W     (OPC_W),
    .OP_RTYPE  (OP_RTYPE),
    .OP_LOAD   (OP_LOAD),
    .OP_STORE  (OP_STORE),
    .OP_BRANCH (OP_BRANCH),
    .OP_JUMP   (OP_JUMP)
  ) u_next (
    .upc     (upc),
    .seq     (seq),
    .opcode  (opcode),
    .upc_nxt (upc_nxt)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) upc <= UA_FETCH;
    else        upc <= upc_nxt;
  end

  // checks
  p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (seq == SQ_INC) |=> (upc == $past(upc) + uaddr_t'(1)));

  p_ret_fetch_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (seq == SQ_FETCH) |=> (upc == UA_FETCH));

  p_dsp1_alu_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (seq == SQ_DSP1 && opcode == OP_RTYPE) |=> (upc == UA_REXE));

  p_dsp2_split_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (seq == SQ_DSP2 && opcode == OP_LOAD) |=> (upc == UA_LDRD));

  p_dsp2_miss_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (seq == SQ_DSP2 && opcode != OP_LOAD && opcode != OP_STORE) |=> (upc == UA_FETCH));

  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (upc == UA_FETCH) |=> (upc == UA_DECODE));

  p_mem_excl_r11: assert property (@(posedge clk) disable iff (!rst_q)
    !(ctl[B_MEMRD] && ctl[B_MEMWR]));

  p_upc_range_r4: assert property (@(posedge clk) disable iff (!rst_q)
    int'(upc) < UA_USED);
endmodule

// File: tb/sim_mseq_ctrl.sv
module sim_mseq_ctrl;
  // control word bit layout from R9
  localparam logic [15:0] W_FETCH  = 16'(1 << 0) | 16'(1 << 3) | 16'(1 << 5) | 16'(1 << 10);
  localparam logic [15:0] W_DECODE = 16'(3 << 10);
  localparam logic [15:0] W_MADDR  = 16'(1 << 9) | 16'(2 << 10);
  localparam logic [15:0] W_LDRD   = 16'(1 << 2) | 16'(1 << 3);
  localparam logic [15:0] W_LDWB   = 16'(1 << 6) | 16'(1 << 8);
  localparam logic [15:0] W_STWR   = 16'(1 << 2) | 16'(1 << 4);
  localparam logic [15:0] W_REXE   = 16'(1 << 9) | 16'(2 << 12);
  localparam logic [15:0] W_RWB    = 16'(1 << 7) | 16'(1 << 8);
  localparam logic [15:0] W_BR     = 16'(1 << 1) | 16'(1 << 9) | 16'(1 << 12) | 16'(1 << 14);
  localparam logic [15:0] W_JMP    = 16'(1 << 0) | 16'(2 << 14);

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  opcode;
  logic [15:0] ctl;
  int          total = 0;
  int          bad = 0;
  logic        mon_on = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  mseq_ctrl u0 (.clk(clk), .rst_n(rst_n), .opcode(opcode), .ctl(ctl));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: ctl=%h expected %h", req, got, exp);
    end
  endtask

  task automatic push(input string req, input logic [15:0] w);
    exp_q.push_back(w);
    tag_q.push_back(req);
  endtask

  // monitor: one expected word per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && exp_q.size() > 0) chk(tag_q.pop_front(), ctl, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic run(input logic [5:0] op, input int n);
    opcode = op;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n  = 1'b0;
    opcode = 6'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset word", ctl, W_FETCH);

    // program of expectations
    push("R2 fetch", W_FETCH); push("R3 decode", W_DECODE);
    push("R4 alu exe", W_REXE); push("R3 alu wb", W_RWB);
    push("R6 fetch", W_FETCH); push("R2 decode", W_DECODE);
    push("R4 ld addr", W_MADDR); push("R5 ld rd", W_LDRD); push("R5 ld wb", W_LDWB);
    push("R6 fetch", W_FETCH); push("R2 decode", W_DECODE);
    push("R4 st addr", W_MADDR); push("R5 st wr", W_STWR);
    push("R6 fetch", W_FETCH); push("R2 decode", W_DECODE); push("R4 branch", W_BR);
    push("R6 fetch", W_FETCH); push("R2 decode", W_DECODE); push("R4 jump", W_JMP);
    push("R6 fetch", W_FETCH); push("R2 decode", W_DECODE);
    push("R7 unmapped", W_FETCH); push("R7 decode", W_DECODE);
    push("R4 ld addr", W_MADDR);
    push("R8 dsp2 miss", W_FETCH); push("R2 decode", W_DECODE);
    push("R4 ld addr", W_MADDR); push("R5 live st", W_STWR);
    push("R6 fetch", W_FETCH);

    rst_n = 1'b1;
    @(posedge clk);
    #1 chk("R1 first edge", ctl, W_FETCH);
    @(posedge clk);
    #1 chk("R1 second edge", ctl, W_FETCH);
    mon_on = 1'b1;
    @(negedge clk);
    run(6'h00, 4);
    run(6'h23, 5);
    run(6'h2B, 4);
    run(6'h04, 3);
    run(6'h02, 3);
    run(6'h3F, 2);          // R7 unmapped in first table
    run(6'h23, 2);          // decode as load ...
    run(6'h04, 1);          // ... R8 branch code at address compute
    run(6'h23, 2);          // decode as load ...
    run(6'h2B, 2);          // ... store code picked by second table (R5)
    chk("R3 queue drained", 16'(exp_q.size()), 16'h0);

    // R10 reset in the middle of an instruction
    mon_on = 1'b0;
    opcode = 6'h23;
    repeat (2) @(negedge clk);   // fetch, decode -> now address compute
    chk("R10 pre", ctl, W_MADDR);
    rst_n = 1'b0;
    #1 chk("R10 async", ctl, W_FETCH);
    repeat (3) @(negedge clk);
    chk("R10 held", ctl, W_FETCH);
    push("R10 fetch", W_FETCH); push("R10 decode", W_DECODE);
    push("R10 branch", W_BR); push("R10 fetch", W_FETCH);
    opcode = 6'h04;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    mon_on = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 queue drained", 16'(exp_q.size()), 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule